// File: doc/BRIEF.md
# Multi-Polynomial Parallel PRBS Checker

This block checks a word of received data each cycle against one of five standard pseudo-random binary sequences. A static select input picks the polynomial. The datapath width is a parameter, normally 10 or 64 bits.

The checker synchronizes to the incoming stream by itself. It does not hold a local copy of the generator. Instead, every received bit is predicted from two earlier received bits taken at the tap distances of the selected polynomial. Those earlier bits may come from the same word or from a 31-bit history of earlier words. A failed prediction is an error.

There are two outputs:
- A sticky done flag. It is set once a full sequence period's worth of bits has been received.
- An error flag. It is stretched over several cycles so that logic in a slower or unrelated clock domain can sample it through its own synchronizer.

A clear input drops both flags and restarts the period count. The reset is asynchronous and active-low, and it is expected to be released synchronously by the reset network upstream.

Top module: `prbs_mpoly_checker`

## Requirements
- R1: `poly_sel` selects the polynomial. Code 0 is x^7+x^6+1, 1 is x^9+x^5+1, 2 is x^15+x^14+1, 3 is x^23+x^18+1, and 4 is x^31+x^28+1. Codes 5, 6 and 7 behave as code 4.
- R2: Bit 0 of `rx_data` is the earliest bit of a word in time, and bit DATA_W-1 is the latest. A clean sequence sent in this order raises no error.
- R3: A received bit r(t) is in error when it differs from r(t-n) XOR r(t-k), where n is the order and k is the smaller exponent. The earlier bits may come from earlier words.
- R4: After reset or a change of `poly_sel`, a bit is not checked until n bits have been received before it on the current polynomial.
- R5: A cycle with `rx_valid` low has no effect on the history, the error detection or the period count, whatever `rx_data` holds.
- R6: `seq_done` goes high after the clock edge at which the number of valid bits received since the last restart reaches 2^n-1. Before that edge it is low. It is low after reset.
- R7: Once high, `seq_done` stays high until `err_clr` is asserted. Further words, idle cycles and polynomial changes do not drop it.
- R8: After the edge of a valid word that contains an error, `err_flag` is high for exactly STRETCH (default 8) cycles. A new error word reloads the full length. `err_flag` is low after reset.
- R9: `err_clr` makes both `err_flag` and `seq_done` low after its edge and restarts the period count. The clear wins over an error in the same word. The word presented in that cycle still enters the history.
- R10: A change of `poly_sel` restarts the period count. Bits before the change do not count toward the new polynomial's period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poly_sel | input | 3 | Polynomial select code (R1) |
| rx_valid | input | 1 | Qualifies `rx_data` for this cycle |
| rx_data | input | DATA_W | Received word, bit 0 earliest |
| err_clr | input | 1 | Clears both flags and restarts the period count |
| err_flag | output | 1 | Pulse-extended error indication |
| seq_done | output | 1 | Sticky full-period flag |

## Verification
The hardest states to reach from the ports involve history that spans several words.

One is a single corrupted bit that comes back as follow-on errors in later words. The bench checks that case by reloading the error stretch while a clear is pending.

Another is a polynomial switch whose new window still holds bits of the old sequence.

To reach these, the stimulus keeps its own generator history. That history absorbs any garbage words that are deliberately sent, so the stream stays consistent across switches. Directed cases include:
- a lone error followed by idle cycles, to measure the stretch;
- a clear colliding with an error word;
- a switch after hundreds of bits, to prove the period count restarted.

A long random run then mixes all eight select codes, valid gaps, single-bit flips and clears, and compares both outputs every cycle.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  // Longest supported order; the history register holds this many bits.
  localparam int HIST_W = 31;
  localparam int ORD_W  = 6;
  localparam int LEN_W  = 32;

  typedef enum logic [2:0] {
    SEL_P7  = 3'd0,
    SEL_P9  = 3'd1,
    SEL_P15 = 3'd2,
    SEL_P23 = 3'd3,
    SEL_P31 = 3'd4
  } poly_sel_e;

  typedef struct packed {
    logic [ORD_W-1:0] order;
    logic [ORD_W-1:0] tap;
  } poly_cfg_t;

  function automatic poly_cfg_t decode_poly(input logic [2:0] sel);
    poly_cfg_t cfg;
    case (sel)
      SEL_P7:  begin cfg.order = 6'd7;  cfg.tap = 6'd6;  end
      SEL_P9:  begin cfg.order = 6'd9;  cfg.tap = 6'd5;  end
      SEL_P15: begin cfg.order = 6'd15; cfg.tap = 6'd14; end
      SEL_P23: begin cfg.order = 6'd23; cfg.tap = 6'd18; end
      default: begin cfg.order = 6'd31; cfg.tap = 6'd28; end
    endcase
    return cfg;
  endfunction

  function automatic logic [LEN_W-1:0] seq_length(input logic [ORD_W-1:0] order);
    return (LEN_W'(1) << order) - LEN_W'(1);
  endfunction

endpackage

// File: rtl/prbs_bit_predictor.sv
module prbs_bit_predictor #(
  parameter int DATA_W = 10,
  parameter int HIST_W = 31,
  parameter int ORD_W  = 6
) (
  input  logic [HIST_W-1:0] hist_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ORD_W-1:0]  order_i,
  input  logic [ORD_W-1:0]  tap_i,
  input  logic [ORD_W-1:0]  fill_i,
  output logic [DATA_W-1:0] miss_o,
  output logic [HIST_W-1:0] hist_next_o
);

  localparam int CAT_W = HIST_W + DATA_W;
  localparam int IDX_W = $clog2(CAT_W);

  // Time-ordered bit window: history (newest at top) followed by this word.
  logic [CAT_W-1:0] window;
  assign window = {data_i, hist_i};

  generate
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
      localparam int POS = HIST_W + gi;
      logic [IDX_W-1:0] idx_far;
      logic [IDX_W-1:0] idx_near;
      logic             predicted;
      logic             armed;
      assign idx_far   = IDX_W'(POS) - IDX_W'(order_i);
      assign idx_near  = IDX_W'(POS) - IDX_W'(tap_i);
      assign predicted = window[idx_far] ^ window[idx_near];
      // A bit is only judged once `order` bits precede it on this polynomial.
      assign armed     = (int'(fill_i) + gi) >= int'(order_i);
      assign miss_o[gi] = armed && (window[POS] != predicted);
    end
  endgenerate

  assign hist_next_o = window[CAT_W-1 -: HIST_W];

endmodule

// File: rtl/prbs_period_tracker.sv
module prbs_period_tracker #(
  parameter int DATA_W = 10,
  parameter int LEN_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_en,
  input  logic             restart,
  input  logic             clr,
  input  logic [LEN_W-1:0] seq_len,
  output logic             seq_done
);

  logic [LEN_W-1:0] cnt_q, cnt_d, cnt_eff;
  logic [LEN_W:0]   sum;
  logic             done_q, done_d;
  logic             reach;
  logic             upd;

  always_comb begin
    cnt_eff = restart ? '0 : cnt_q;
    sum     = {1'b0, cnt_eff} + (LEN_W+1)'(DATA_W);
    reach   = sum >= {1'b0, seq_len};
    cnt_d   = cnt_eff;
    done_d  = done_q;
    if (clr) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (word_en) begin
      cnt_d  = reach ? seq_len : sum[LEN_W-1:0];
      done_d = done_q | reach;
    end
    upd = clr | word_en | restart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (upd) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign seq_done = done_q;

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !clr |=> done_q);

  assert_clr_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !done_q);

  assert_cnt_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> cnt_q <= seq_len);

  assert_done_needs_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(word_en));

endmodule

// File: rtl/prbs_err_stretch.sv
module prbs_err_stretch #(
  parameter int STRETCH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_event,
  input  logic clr,
  output logic err_flag
);

  localparam int CNT_W = $clog2(STRETCH + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (err_event)     cnt_d = CNT_W'(STRETCH);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    upd = clr | err_event | (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  assign err_flag = cnt_q != '0;

  assert_err_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_event && !clr |=> err_flag);

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !err_flag);

  assert_stretch_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(STRETCH));

endmodule

// File: rtl/prbs_mpoly_checker.sv
module prbs_mpoly_checker
  import prbs_chk_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int STRETCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        poly_sel,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              err_clr,
  output logic              err_flag,
  output logic              seq_done
);

  logic [2:0]        poly_q;
  logic              poly_chg;
  poly_cfg_t         cfg;
  logic [ORD_W-1:0]  fill_q, fill_d, fill_eff;
  logic [HIST_W-1:0] hist_q, hist_d;
  logic [DATA_W-1:0] miss;
  logic              err_event;

  assign cfg      = decode_poly(poly_sel);
  assign poly_chg = poly_sel != poly_q;
  assign fill_eff = poly_chg ? '0 : fill_q;

  always_comb begin
    fill_d = fill_eff;
    if (rx_valid) begin
      if (int'(fill_eff) + DATA_W >= HIST_W) fill_d = ORD_W'(HIST_W);
      else                                   fill_d = ORD_W'(int'(fill_eff) + DATA_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poly_q <= '0;
      fill_q <= '0;
      hist_q <= '0;
    end else begin
      poly_q <= poly_sel;
      fill_q <= fill_d;
      if (rx_valid) hist_q <= hist_d;
    end
  end

  prbs_bit_predictor #(
    .DATA_W (DATA_W),
    .HIST_W (HIST_W),
    .ORD_W  (ORD_W)
  ) i_predictor (
    .hist_i      (hist_q),
    .data_i      (rx_data),
    .order_i     (cfg.order),
    .tap_i       (cfg.tap),
    .fill_i      (fill_eff),
    .miss_o      (miss),
    .hist_next_o (hist_d)
  );

  assign err_event = rx_valid && (|miss);

  prbs_period_tracker #(
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W)
  ) i_period (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_en  (rx_valid),
    .restart  (poly_chg),
    .clr      (err_clr),
    .seq_len  (seq_length(cfg.order)),
    .seq_done (seq_done)
  );

  prbs_err_stretch #(
    .STRETCH (STRETCH)
  ) i_stretch (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_event (err_event),
    .clr       (err_clr),
    .err_flag  (err_flag)
  );

  assert_idle_hist_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(hist_q));

  assert_fill_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= ORD_W'(HIST_W));

  assert_fresh_poly_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && poly_chg && (int'(cfg.order) >= DATA_W) |-> !err_event);

  assert_idle_no_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid && !err_flag && !err_clr |=> !err_flag);

endmodule

// File: tb/test_prbs_mpoly_checker.sv
module test_prbs_mpoly_checker;

  localparam int DW  = 10;
  localparam int HW  = 31;
  localparam int STR = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    poly_sel;
  logic          rx_valid;
  logic [DW-1:0] rx_data;
  logic          err_clr;
  logic          err_flag;
  logic          seq_done;

  always #5 clk = ~clk;

  prbs_mpoly_checker #(.DATA_W(DW), .STRETCH(STR)) i_prbs_mpoly_checker (
    .clk(clk), .rst_n(rst_n), .poly_sel(poly_sel), .rx_valid(rx_valid),
    .rx_data(rx_data), .err_clr(err_clr), .err_flag(err_flag), .seq_done(seq_done)
  );

  int checks = 0;
  int errors = 0;

  // Reference state built from the requirements.
  logic [HW-1:0] m_hist;
  int            m_fill;
  longint        m_cnt;
  bit            m_done;
  int            m_str;
  logic [2:0]    m_poly;
  logic [HW-1:0] g_hist;  // stimulus generator history, newest at top

  task automatic taps(input logic [2:0] s, output int n, output int k);
    case (s)
      3'd0:    begin n = 7;  k = 6;  end
      3'd1:    begin n = 9;  k = 5;  end
      3'd2:    begin n = 15; k = 14; end
      3'd3:    begin n = 23; k = 18; end
      default: begin n = 31; k = 28; end
    endcase
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit v, input logic [DW-1:0] d, input bit c, input logic [2:0] s);
    int n, k, fe;
    longint ce, len;
    bit chg, err;
    logic [HW+DW-1:0] cat;
    taps(s, n, k);
    chg = (s != m_poly);
    fe  = chg ? 0 : m_fill;
    ce  = chg ? 0 : m_cnt;
    len = (64'd1 << n) - 1;
    err = 1'b0;
    if (v) begin
      cat = {d, m_hist};
      for (int i = 0; i < DW; i++) begin
        if (fe + i >= n && (cat[HW+i] != (cat[HW+i-n] ^ cat[HW+i-k]))) err = 1'b1;
      end
      m_hist = cat[HW+DW-1 -: HW];
      m_fill = (fe + DW > HW) ? HW : fe + DW;
    end else begin
      m_fill = fe;
    end
    if (c) begin
      m_cnt = 0; m_done = 1'b0; m_str = 0;
    end else begin
      if (v) begin
        if (ce + DW >= len) begin m_done = 1'b1; m_cnt = len; end
        else m_cnt = ce + DW;
      end else m_cnt = ce;
      if (err) m_str = STR;
      else if (m_str > 0) m_str--;
    end
    m_poly = s;
  endtask

  task automatic cycle(input bit v, input logic [DW-1:0] d, input bit c, input logic [2:0] s);
    poly_sel = s; rx_valid = v; rx_data = d; err_clr = c;
    model_step(v, d, c, s);
    @(posedge clk);
    @(negedge clk);
    check("R8", err_flag, m_str != 0);
    check("R6", seq_done, m_done);
  endtask

  task automatic gen_word(input logic [2:0] s, output logic [DW-1:0] w);
    int n, k;
    logic nb;
    taps(s, n, k);
    for (int i = 0; i < DW; i++) begin
      nb = g_hist[HW-n] ^ g_hist[HW-k];
      w[i] = nb;
      g_hist = {nb, g_hist[HW-1:1]};
    end
  endtask

  task automatic push_raw(input logic [DW-1:0] w);
    for (int i = 0; i < DW; i++) g_hist = {w[i], g_hist[HW-1:1]};
  endtask

  task automatic clean_words(input logic [2:0] s, input int count);
    logic [DW-1:0] w;
    for (int i = 0; i < count; i++) begin
      gen_word(s, w);
      cycle(1'b1, w, 1'b0, s);
    end
  endtask

  task automatic idle(input logic [2:0] s, input int count);
    for (int i = 0; i < count; i++) cycle(1'b0, DW'($urandom), 1'b0, s);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R6: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] w;
    logic [2:0] sel;
    bit v, c;
    void'($urandom(32'd7321));
    rst_n = 1'b0; poly_sel = 3'd0; rx_valid = 1'b0; rx_data = '0; err_clr = 1'b0;
    m_hist = '0; m_fill = 0; m_cnt = 0; m_done = 1'b0; m_str = 0; m_poly = 3'd0;
    g_hist = 31'h5A5A1234;
    repeat (3) @(negedge clk);
    check("R8", err_flag, 1'b0);
    check("R6", seq_done, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // PRBS7 period: 127 bits -> done after the 13th 10-bit word.
    clean_words(3'd0, 12);
    check("R6", seq_done, 1'b0);
    clean_words(3'd0, 1);
    check("R6", seq_done, 1'b1);
    check("R2", err_flag, 1'b0);

    // Stickiness across idle cycles and more words.
    idle(3'd0, 5);
    clean_words(3'd0, 3);
    check("R7", seq_done, 1'b1);

    // Single flipped bit, then idle: stretch length.
    gen_word(3'd0, w);
    cycle(1'b1, w ^ DW'(10'h010), 1'b0, 3'd0);
    check("R3", err_flag, 1'b1);
    idle(3'd0, 7);
    check("R8", err_flag, 1'b1);
    idle(3'd0, 1);
    check("R8", err_flag, 1'b0);
    clean_words(3'd0, 1);
    check("R3", err_flag, 1'b1);  // follow-on error from history

    // Clear colliding with an error word.
    idle(3'd0, 10);
    gen_word(3'd0, w);
    cycle(1'b1, w ^ DW'(10'h200), 1'b1, 3'd0);
    check("R9", err_flag, 1'b0);
    check("R9", seq_done, 1'b0);
    clean_words(3'd0, 3);
    idle(3'd0, 10);
    cycle(1'b0, '0, 1'b1, 3'd0);

    // Idle cycles with garbage data change nothing.
    idle(3'd0, 6);
    clean_words(3'd0, 3);
    check("R5", err_flag, 1'b0);

    // Polynomial switch: first word on the new polynomial is not judged.
    w = DW'($urandom);
    push_raw(w);
    cycle(1'b1, w, 1'b0, 3'd2);
    check("R4", err_flag, 1'b0);
    clean_words(3'd2, 3);
    check("R4", err_flag, 1'b0);

    // Period count restarts on a switch.
    cycle(1'b0, '0, 1'b1, 3'd2);
    clean_words(3'd2, 30);
    clean_words(3'd0, 12);
    check("R10", seq_done, 1'b0);
    clean_words(3'd0, 1);
    check("R10", seq_done, 1'b1);

    // Other polynomials.
    cycle(1'b0, '0, 1'b1, 3'd1);
    clean_words(3'd1, 51);
    check("R1", seq_done, 1'b0);
    clean_words(3'd1, 1);
    check("R1", seq_done, 1'b1);
    cycle(1'b0, '0, 1'b1, 3'd2);
    clean_words(3'd2, 3276);
    check("R1", seq_done, 1'b0);
    clean_words(3'd2, 1);
    check("R1", seq_done, 1'b1);
    clean_words(3'd3, 200);
    check("R1", err_flag, 1'b0);
    clean_words(3'd4, 200);
    check("R1", err_flag, 1'b0);
    clean_words(3'd5, 200);
    check("R1", err_flag, 1'b0);

    // Random mix, compared every cycle.
    sel = 3'd0;
    for (int cyc = 0; cyc < 15000; cyc++) begin
      if (cyc % 700 == 0) sel = 3'($urandom_range(0, 7));
      v = ($urandom_range(0, 3) != 0);
      c = ($urandom_range(0, 99) == 0);
      if (v) begin
        gen_word(sel, w);
        if ($urandom_range(0, 39) == 0) w = w ^ (DW'(1) << $urandom_range(0, DW-1));
      end else begin
        w = DW'($urandom);
      end
      cycle(v, w, c, sel);
    end

    finish_run();
  end

endmodule